// File: doc/BRIEF.md
# Cache Access-Mode Predictor

This block guesses, ahead of each cache lookup, whether that lookup will hit. A guessed hit tells the cache controller to read only the predicted way. A guessed miss tells it to use phased lookup, where all tags are compared before any data is read. The controller raises a request strobe with the set index of the coming access and reads the guess in the same cycle. When that access resolves, the controller raises an update strobe with the real outcome, and the block trains on it.

The block holds one shared pattern table of 2-bit saturating counters, a global outcome history, and one outcome history per set. A configuration input picks how the table is indexed. The choices are: one fixed counter, the global history, the history of the requested set, or the global history XORed with the set index. The table index used for a guess is held until the next request, so training lands on the counter that made the guess.

There is no back-pressure. The block accepts a request and an update in every cycle, and a new request may arrive in the same cycle as the update for the one before it.

Top module: `amp_predictor`

## Requirements
- R1: After reset, every counter holds weakly-hit (2'b10), and every history register, global and per-set, holds all ones. The first request in any mode therefore predicts hit.
- R2: With cfg_mode = 0, every request uses table entry 0 as a single counter. An update with upd_hit = 1 raises the counter, and an update with upd_hit = 0 lowers it. The counter saturates at 0 and at 3, and the guess is hit when counter bit 1 is set.
- R3: With cfg_mode = 1, the table index is the K-bit global history.
- R4: Every update shifts the outcome into bit 0 of the global history, with 1 for a hit and 0 for a miss, and moves the older bits up by one place. In the same cycle it shifts the outcome into the history of the set of the latched request. Both shifts happen in every mode.
- R5: With cfg_mode = 2, the table index is the history register of the requested set. There is one such register per set, and all of them index the same shared table.
- R6: With cfg_mode = 3, the table index is the global history XOR the set index, with the set index zero-extended to K bits.
- R7: An update trains the counter at the index of the most recent request. That index stays latched across idle cycles until the next request.
- R8: When a request and an update arrive in the same cycle, the update trains the previous request's index. The new guess reads the counters and histories as they were before that update.
- R9: A cycle without upd_valid leaves all counters and histories unchanged.
- R10: pred_hit is 0 in any cycle without req_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Scheme: 0 single counter, 1 global history, 2 per-set history, 3 XOR-indexed |
| req_valid | input | 1 | Strobe for a lookup request in this cycle |
| req_set | input | 4 | Set index of the requested access |
| pred_hit | output | 1 | Guess for this request: 1 means use way-predicted lookup, 0 means use phased lookup |
| upd_valid | input | 1 | Strobe: outcome of the last request is available |
| upd_hit | input | 1 | Outcome: 1 means hit, 0 means miss |

## Verification
A wrong counter value or a wrong history bit has no effect at the ports until a later request reads that table entry. It then shows as a flipped pred_hit, anywhere from the next cycle to many accesses later. For this reason the bench compares every request against a reference model of the tables and histories, in all four modes. It uses long outcome runs so that saturation shows, and patterns tied to each set so that the per-set and XOR indexing read different entries from the global scheme. It also checks overlapped request/update cycles and idle gaps, so that a latching or ordering error appears at the first request that depends on it.

// File: rtl/amp_pkg.sv
package amp_pkg;
  typedef enum logic [1:0] {
    AMP_SINGLE = 2'd0,
    AMP_GLOBAL = 2'd1,
    AMP_PERSET = 2'd2,
    AMP_XOR    = 2'd3
  } amp_mode_e;

  localparam logic [1:0] CNT_INIT = 2'b10;

  function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/amp_history.sv
module amp_history #(
  parameter int K    = 6,
  parameter int SETS = 16,
  parameter int SW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic          upd_hit,
  input  logic [SW-1:0] upd_set,
  input  logic [SW-1:0] rd_set,
  output logic [K-1:0]  ghist,
  output logic [K-1:0]  phist_rd
);
  logic [K-1:0] ghist_q;
  logic [K-1:0] phist_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n)         ghist_q <= '1;
    else if (upd_valid) ghist_q <= {ghist_q[K-2:0], upd_hit};
  end

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n)
        phist_q[g] <= '1;
      else if (upd_valid && upd_set == SW'(g))
        phist_q[g] <= {phist_q[g][K-2:0], upd_hit};
    end
  end

  assign ghist    = ghist_q;
  assign phist_rd = phist_q[rd_set];
endmodule

// File: rtl/amp_index_sel.sv
module amp_index_sel
  import amp_pkg::*;
#(
  parameter int K  = 6,
  parameter int SW = 4
) (
  input  logic [1:0]    mode,
  input  logic [SW-1:0] set,
  input  logic [K-1:0]  ghist,
  input  logic [K-1:0]  phist,
  output logic [K-1:0]  idx
);
  amp_mode_e m;
  assign m = amp_mode_e'(mode);

  always_comb begin
    unique case (m)
      AMP_SINGLE: idx = '0;
      AMP_GLOBAL: idx = ghist;
      AMP_PERSET: idx = phist;
      AMP_XOR:    idx = ghist ^ K'(set);
      default:    idx = '0;
    endcase
  end
endmodule

// File: rtl/amp_pattern_table.sv
module amp_pattern_table
  import amp_pkg::*;
#(
  parameter int K = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] rd_idx,
  output logic [1:0]   rd_cnt,
  input  logic         wr_en,
  input  logic [K-1:0] wr_idx,
  input  logic         wr_up
);
  localparam int DEPTH = 1 << K;
  logic [1:0] cnt_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[e] <= CNT_INIT;
      else if (wr_en && wr_idx == K'(e))
        cnt_q[e] <= sat_step(cnt_q[e], wr_up);
    end
  end

  assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/amp_predictor.sv
module amp_predictor #(
  parameter int K    = 6,
  parameter int SETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_mode,
  input  logic                     req_valid,
  input  logic [$clog2(SETS)-1:0]  req_set,
  output logic                     pred_hit,
  input  logic                     upd_valid,
  input  logic                     upd_hit
);
  localparam int SW = $clog2(SETS);

  logic [K-1:0]  ghist_q, phist_rd, rd_idx, lat_idx_q;
  logic [SW-1:0] lat_set_q;
  logic [1:0]    rd_cnt;

  amp_history #(.K(K), .SETS(SETS), .SW(SW)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_hit(upd_hit), .upd_set(lat_set_q),
    .rd_set(req_set), .ghist(ghist_q), .phist_rd(phist_rd)
  );

  amp_index_sel #(.K(K), .SW(SW)) u_isel (
    .mode(cfg_mode), .set(req_set), .ghist(ghist_q), .phist(phist_rd), .idx(rd_idx)
  );

  amp_pattern_table #(.K(K)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt),
    .wr_en(upd_valid), .wr_idx(lat_idx_q), .wr_up(upd_hit)
  );

  // Hold the index and set of the last request until its outcome is trained.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_idx_q <= '0;
      lat_set_q <= '0;
    end else if (req_valid) begin
      lat_idx_q <= rd_idx;
      lat_set_q <= req_set;
    end
  end

  assign pred_hit = req_valid & rd_cnt[1];
endmodule

// File: rtl/amp_predictor_chk.sv
module amp_predictor_chk #(
  parameter int K = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         pred_hit,
  input logic         upd_valid,
  input logic         upd_hit,
  input logic [K-1:0] ghist,
  input logic [K-1:0] rd_idx,
  input logic [K-1:0] lat_idx
);
  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[K-2:0]), $past(upd_hit)});

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  assert_latch_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lat_idx == $past(rd_idx));

  assert_latch_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(lat_idx));

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !pred_hit);
endmodule

bind amp_predictor amp_predictor_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_hit(pred_hit),
  .upd_valid(upd_valid), .upd_hit(upd_hit), .ghist(ghist_q),
  .rd_idx(rd_idx), .lat_idx(lat_idx_q)
);

// File: tb/amp_predictor_bench.sv
module amp_predictor_bench;
  localparam int K = 6, SETS = 16, SW = 4, DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0;
  logic req_valid = 0, upd_valid = 0, upd_hit = 0;
  logic [SW-1:0] req_set = 0;
  logic pred_hit;

  always #2.5 clk = ~clk;

  amp_predictor u_amp_predictor (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req_valid(req_valid),
    .req_set(req_set), .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_hit(upd_hit)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit    exp_q[$];
  string tag_q[$];

  // reference model
  logic [1:0]   m_cnt [DEPTH];
  logic [K-1:0] m_gh;
  logic [K-1:0] m_ph [SETS];
  logic [K-1:0] m_lat_idx;
  logic [SW-1:0] m_lat_set;

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_cnt[i] = 2'b10;
    for (int i = 0; i < SETS; i++) m_ph[i] = '1;
    m_gh = '1; m_lat_idx = '0; m_lat_set = '0;
  endtask

  task automatic do_reset(input logic [1:0] mode);
    @(negedge clk);
    rst_n = 0; req_valid = 0; upd_valid = 0; cfg_mode = mode;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // driver: drives one cycle and pushes the expected guess
  task automatic step(input bit rq, input int set, input bit up, input bit hit, input string tag);
    logic [K-1:0] idx;
    @(negedge clk);
    req_valid = rq; req_set = SW'(set); upd_valid = up; upd_hit = hit;
    case (cfg_mode)
      2'd0: idx = '0;
      2'd1: idx = m_gh;
      2'd2: idx = m_ph[set];
      default: idx = m_gh ^ K'(set);
    endcase
    if (rq) begin
      exp_q.push_back(m_cnt[idx][1]);
      tag_q.push_back(tag);
    end
    if (up) begin
      if (hit) m_cnt[m_lat_idx] = (m_cnt[m_lat_idx] == 3) ? 2'd3 : m_cnt[m_lat_idx] + 2'd1;
      else     m_cnt[m_lat_idx] = (m_cnt[m_lat_idx] == 0) ? 2'd0 : m_cnt[m_lat_idx] - 2'd1;
      m_gh = {m_gh[K-2:0], hit};
      m_ph[m_lat_set] = {m_ph[m_lat_set][K-2:0], hit};
    end
    if (rq) begin
      m_lat_idx = idx;
      m_lat_set = SW'(set);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (req_valid) begin
        if (exp_q.size() > 0) begin
          bit e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          total++;
          if (pred_hit !== e) begin
            bad++;
            $display("FAIL %s: pred_hit=%b expected=%b", t, pred_hit, e);
          end
        end
      end else begin
        total++;
        if (pred_hit !== 1'b0) begin
          bad++;
          $display("FAIL R10: pred_hit=%b expected=0 while idle", pred_hit);
        end
      end
    end
  end

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      // R1: first guess after reset is hit
      step(1, 5, 0, 0, "R1");
      step(0, 0, 1, 0, "R1");
      // R2/R4 saturation: long miss run, then long hit run (sequential)
      for (int i = 0; i < 6; i++) begin
        step(1, i, 0, 0, mode_tag(2'(m)));
        step(0, 0, 1, 0, "R4");
      end
      for (int i = 0; i < 6; i++) begin
        step(1, i, 0, 0, mode_tag(2'(m)));
        step(0, 0, 1, 1, "R4");
      end
      // R8: overlapped request + update of the previous access
      step(1, 3, 0, 0, "R8");
      for (int i = 0; i < 40; i++)
        step(1, (i * 7) % SETS, 1, ((i % 3) != 0) || (i % SETS < 4), "R8");
      step(0, 0, 1, 0, "R8");
      // R7/R9: latched index survives idle cycles; idle cycles change nothing
      step(1, 9, 0, 0, "R7");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R9");
      step(0, 0, 1, 0, "R7");
      step(1, 9, 0, 0, "R7");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R9");
      step(1, 9, 0, 0, "R9");
      step(0, 0, 1, 1, "R7");
      // set-dependent pattern: odd sets miss, even sets hit
      lfsr = 16'hACE1;
      for (int i = 0; i < 120; i++) begin
        int s;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s = int'(lfsr[3:0]);
        step(1, s, 0, 0, mode_tag(2'(m)));
        step(0, 0, 1, (s % 2) == 0, "R5");
      end
    end
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule